// File: doc/BRIEF.md
# Convolution Core Host Register Interface

This block is the bus-facing front end of one convolution core. A Wishbone host reaches it through a 1 KiB window that splits into four 256-byte regions. The first holds the control, geometry and output-format registers. The second and third are the image and kernel stores, which the host can only fill. The fourth is the result store, which the host can only read. Every region holds 32-bit words at 4-byte steps. Each store is a two-port on-chip array. One port belongs to the host. The other belongs to the engine.

The host writes image rows and kernels, then programs the geometry and output format. It then sets the go bit, which sends a one-cycle start pulse to the engine. Afterwards it polls the status word. The engine reports completion and accumulator overflow on two inputs, and the block keeps both for the host to read. Overflow stays set until the host clears it on purpose. A soft-reset bit sends a one-cycle pulse to the engine and clears the overflow flag. It leaves the configuration untouched.

Top module: `conv_host_regs`

## Requirements
- R1: Each access with CYC and STB high is acknowledged in the following cycle. The ack lasts one cycle. Read data is valid while ack is high.
- R2: Offset bits 9:8 select the region: 0 for registers, 1 for image, 2 for kernel, 3 for result. Bits 7:2 give the word index inside the region.
- R3: A host write to the image or kernel region stores the low IMG_W or KRN_W bits of the data. The engine reads that word at the same index one cycle after presenting the address. A host read of either region returns zero.
- R4: The engine writes the result region. A host read returns the stored value, zero-extended to 32 bits. A host write to the result region changes nothing.
- R5: In the status/control word at offset 0x000, bit 0 is done, bit 1 is overflow, bit 2 is go and bit 3 is soft reset. Go, soft reset and bits 31:4 read as zero. After reset all registers read zero, and no engine pulse is active.
- R6: Writing 1 to bit 2 of offset 0x000 raises the engine start output for exactly one cycle. That cycle is the cycle in which the write is acknowledged.
- R7: Done is set by the engine's done input. It stays set, and a write with bit 2 clear leaves it alone. A write with bit 2 set clears it, and this clear wins over a done input in the same cycle.
- R8: Overflow is set by the engine's overflow input and stays set. Writing 1 to bit 1 clears it, and writing 0 to bit 1 does not. An overflow input in the same cycle as a clear keeps the flag set.
- R9: Writing 1 to bit 3 raises the engine soft-reset output for exactly one cycle, in the ack cycle. The same write clears overflow. The geometry and output-format registers keep their values.
- R10: The geometry word at offset 0x004 holds four fields. Bits 2:0 hold kernel columns minus one, bits 15:8 hold image columns minus one, bits 18:16 hold kernel count minus one, and bits 31:24 hold stride. Its other bits read zero. Each field drives its engine output from the ack cycle on.
- R11: The output-format word at offset 0x008 holds four fields. Bits 7:0 hold result columns minus one, bits 11:8 hold the shift amount, bit 16 holds the kernel address mode, and bits 20:18 hold the row mask. Its other bits read zero. Each field drives its engine output from the ack cycle on.
- R12: Register-region offsets from 0x00C to 0x0FC read zero. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | RAM_AW+4 | Byte offset inside the core window |
| wb_dat_i | input | 32 | Write data |
| wb_dat_o | output | 32 | Read data |
| wb_ack_o | output | 1 | Acknowledge |
| eng_start_o | output | 1 | One-cycle start pulse |
| eng_srst_o | output | 1 | One-cycle engine soft reset |
| eng_done_i | input | 1 | Engine completion report |
| eng_ovf_i | input | 1 | Engine accumulator overflow report |
| cfg_kcols_o | output | 3 | Kernel columns minus one |
| cfg_icols_o | output | 8 | Image columns minus one |
| cfg_nkern_o | output | 3 | Kernel count minus one |
| cfg_stride_o | output | 8 | Stride |
| cfg_rcols_o | output | 8 | Result columns minus one |
| cfg_shift_o | output | 4 | Accumulator shift |
| cfg_kmode_o | output | 1 | Kernel address mode |
| cfg_rmask_o | output | 3 | Row mask |
| eng_img_addr_i | input | RAM_AW | Engine image read index |
| eng_img_data_o | output | IMG_W | Engine image read data |
| eng_krn_addr_i | input | RAM_AW | Engine kernel read index |
| eng_krn_data_o | output | KRN_W | Engine kernel read data |
| eng_res_we_i | input | 1 | Engine result write enable |
| eng_res_addr_i | input | RAM_AW | Engine result write index |
| eng_res_data_i | input | RES_W | Engine result write data |

## Verification
The bench builds the block with its defaults: RAM_AW of 6, which gives 64 words per region, 24-bit image and kernel words, and 8-bit result words. These widths let it test the dropping of the top byte on image and kernel writes and the zero-extension of result reads. The 64-word depth lets it reach the last word of each store, at 0x1FC, 0x2FC and 0x3FC, and check that the last word of one region does not alias into another. A simple engine stand-in drives the done and overflow inputs. It times them to land in the same cycle as go or clear writes, which makes both priority rules visible at the bus.

// File: rtl/cbf_pkg.sv
package cbf_pkg;

    localparam int WORD_W = 32;

    typedef enum logic [1:0] {
        RGN_CSR = 2'd0,
        RGN_IMG = 2'd1,
        RGN_KRN = 2'd2,
        RGN_RES = 2'd3
    } region_e;

    // word indices inside the register region
    localparam int CSR_CTRL = 0;
    localparam int CSR_GEOM = 1;
    localparam int CSR_OUTF = 2;

    // control/status bit positions
    localparam int CTL_DONE = 0;
    localparam int CTL_OVF  = 1;
    localparam int CTL_GO   = 2;
    localparam int CTL_SRST = 3;

    typedef struct packed {
        logic [7:0] stride;
        logic [2:0] nkern;
        logic [7:0] icols;
        logic [2:0] kcols;
    } geom_t;

    typedef struct packed {
        logic [2:0] rmask;
        logic       kmode;
        logic [3:0] shift;
        logic [7:0] rcols;
    } outf_t;

    function automatic region_e region_of(input logic [1:0] sel);
        return region_e'(sel);
    endfunction

    function automatic geom_t geom_from_word(input logic [WORD_W-1:0] w);
        geom_t g;
        g.stride = w[31:24];
        g.nkern  = w[18:16];
        g.icols  = w[15:8];
        g.kcols  = w[2:0];
        return g;
    endfunction

    function automatic logic [WORD_W-1:0] geom_to_word(input geom_t g);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[31:24] = g.stride;
        w[18:16] = g.nkern;
        w[15:8]  = g.icols;
        w[2:0]   = g.kcols;
        return w;
    endfunction

    function automatic outf_t outf_from_word(input logic [WORD_W-1:0] w);
        outf_t f;
        f.rmask = w[20:18];
        f.kmode = w[16];
        f.shift = w[11:8];
        f.rcols = w[7:0];
        return f;
    endfunction

    function automatic logic [WORD_W-1:0] outf_to_word(input outf_t f);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[20:18] = f.rmask;
        w[16]    = f.kmode;
        w[11:8]  = f.shift;
        w[7:0]   = f.rcols;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] ctrl_to_word(input logic done, input logic ovf);
        logic [WORD_W-1:0] w;
        w           = '0;
        w[CTL_DONE] = done;
        w[CTL_OVF]  = ovf;
        return w;
    endfunction

endpackage

// File: rtl/cbf_ram.sv
module cbf_ram #(
    parameter int DW = 24,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // registered read; a read of the word being written returns the old value
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_data <= mem[rd_addr];
    end

endmodule

// File: rtl/cbf_csr.sv
module cbf_csr
    import cbf_pkg::*;
#(
    parameter int IW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [IW-1:0]     idx,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data,
    input  logic              eng_done_i,
    input  logic              eng_ovf_i,
    output logic              go_o,
    output logic              srst_o,
    output geom_t             geom_o,
    output outf_t             outf_o
);
    logic  done_q, ovf_q, go_q, srst_q;
    geom_t geom_q;
    outf_t outf_q;

    logic wr_ctrl, wr_geom, wr_outf;
    logic go_req, srst_req, ovf_clr;

    always_comb begin
        wr_ctrl  = wr_en && (idx == IW'(CSR_CTRL));
        wr_geom  = wr_en && (idx == IW'(CSR_GEOM));
        wr_outf  = wr_en && (idx == IW'(CSR_OUTF));
        go_req   = wr_ctrl && wr_data[CTL_GO];
        srst_req = wr_ctrl && wr_data[CTL_SRST];
        ovf_clr  = wr_ctrl && (wr_data[CTL_OVF] || wr_data[CTL_SRST]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            ovf_q  <= 1'b0;
            go_q   <= 1'b0;
            srst_q <= 1'b0;
            geom_q <= '0;
            outf_q <= '0;
        end else begin
            go_q   <= go_req;
            srst_q <= srst_req;
            // a new go clears done even if the engine reports in the same cycle
            if (go_req) begin
                done_q <= 1'b0;
            end else if (eng_done_i) begin
                done_q <= 1'b1;
            end
            // an overflow report beats a clear arriving in the same cycle
            if (eng_ovf_i) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
            if (wr_geom) begin
                geom_q <= geom_from_word(wr_data);
            end
            if (wr_outf) begin
                outf_q <= outf_from_word(wr_data);
            end
        end
    end

    always_comb begin
        if (idx == IW'(CSR_CTRL)) begin
            rd_data = ctrl_to_word(done_q, ovf_q);
        end else if (idx == IW'(CSR_GEOM)) begin
            rd_data = geom_to_word(geom_q);
        end else if (idx == IW'(CSR_OUTF)) begin
            rd_data = outf_to_word(outf_q);
        end else begin
            rd_data = '0;
        end
    end

    assign go_o   = go_q;
    assign srst_o = srst_q;
    assign geom_o = geom_q;
    assign outf_o = outf_q;

    // R6
    go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |=> !go_o);

    // R9
    srst_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        srst_o |=> !srst_o);

    // R7
    done_clear_chk: assert property (@(posedge clk) disable iff (rst)
        go_o |-> !done_q);

    // R8
    ovf_capture_chk: assert property (@(posedge clk) disable iff (rst)
        eng_ovf_i |=> ovf_q);

    // R8
    ovf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf_q && !wr_en) |=> ovf_q);

endmodule

// File: rtl/conv_host_regs.sv
module conv_host_regs
    import cbf_pkg::*;
#(
    parameter int RAM_AW = 6,
    parameter int IMG_W  = 24,
    parameter int KRN_W  = 24,
    parameter int RES_W  = 8,
    localparam int RGN_LSB = RAM_AW + 2,
    localparam int WB_AW   = RAM_AW + 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wb_cyc_i,
    input  logic              wb_stb_i,
    input  logic              wb_we_i,
    input  logic [WB_AW-1:0]  wb_adr_i,
    input  logic [31:0]       wb_dat_i,
    output logic [31:0]       wb_dat_o,
    output logic              wb_ack_o,
    output logic              eng_start_o,
    output logic              eng_srst_o,
    input  logic              eng_done_i,
    input  logic              eng_ovf_i,
    output logic [2:0]        cfg_kcols_o,
    output logic [7:0]        cfg_icols_o,
    output logic [2:0]        cfg_nkern_o,
    output logic [7:0]        cfg_stride_o,
    output logic [7:0]        cfg_rcols_o,
    output logic [3:0]        cfg_shift_o,
    output logic              cfg_kmode_o,
    output logic [2:0]        cfg_rmask_o,
    input  logic [RAM_AW-1:0] eng_img_addr_i,
    output logic [IMG_W-1:0]  eng_img_data_o,
    input  logic [RAM_AW-1:0] eng_krn_addr_i,
    output logic [KRN_W-1:0]  eng_krn_data_o,
    input  logic              eng_res_we_i,
    input  logic [RAM_AW-1:0] eng_res_addr_i,
    input  logic [RES_W-1:0]  eng_res_data_i
);
    logic              ack_q;
    region_e           rgn, rgn_q;
    logic [RAM_AW-1:0] widx;
    logic              req;
    logic              img_we, krn_we, csr_we;
    logic [WORD_W-1:0] csr_rd, csr_rd_q;
    logic [RES_W-1:0]  res_rd;
    logic [WORD_W-1:0] res_word;
    geom_t             geom;
    outf_t             outf;
    logic              unused_adr_bits;

    assign unused_adr_bits = ^wb_adr_i[1:0];

    always_comb begin
        rgn    = region_of(wb_adr_i[RGN_LSB +: 2]);
        widx   = wb_adr_i[2 +: RAM_AW];
        req    = wb_cyc_i && wb_stb_i && !ack_q;
        img_we = req && wb_we_i && (rgn == RGN_IMG);
        krn_we = req && wb_we_i && (rgn == RGN_KRN);
        csr_we = req && wb_we_i && (rgn == RGN_CSR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ack_q    <= 1'b0;
            rgn_q    <= RGN_CSR;
            csr_rd_q <= '0;
        end else begin
            ack_q <= req;
            if (req) begin
                rgn_q    <= rgn;
                csr_rd_q <= csr_rd;
            end
        end
    end

    cbf_csr #(.IW(RAM_AW)) csr_i (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (csr_we),
        .idx        (widx),
        .wr_data    (wb_dat_i),
        .rd_data    (csr_rd),
        .eng_done_i (eng_done_i),
        .eng_ovf_i  (eng_ovf_i),
        .go_o       (eng_start_o),
        .srst_o     (eng_srst_o),
        .geom_o     (geom),
        .outf_o     (outf)
    );

    cbf_ram #(.DW(IMG_W), .AW(RAM_AW)) img_ram_i (
        .clk     (clk),
        .wr_en   (img_we),
        .wr_addr (widx),
        .wr_data (wb_dat_i[IMG_W-1:0]),
        .rd_addr (eng_img_addr_i),
        .rd_data (eng_img_data_o)
    );

    cbf_ram #(.DW(KRN_W), .AW(RAM_AW)) krn_ram_i (
        .clk     (clk),
        .wr_en   (krn_we),
        .wr_addr (widx),
        .wr_data (wb_dat_i[KRN_W-1:0]),
        .rd_addr (eng_krn_addr_i),
        .rd_data (eng_krn_data_o)
    );

    cbf_ram #(.DW(RES_W), .AW(RAM_AW)) res_ram_i (
        .clk     (clk),
        .wr_en   (eng_res_we_i),
        .wr_addr (eng_res_addr_i),
        .wr_data (eng_res_data_i),
        .rd_addr (widx),
        .rd_data (res_rd)
    );

    always_comb begin
        res_word               = '0;
        res_word[RES_W-1:0]    = res_rd;
        wb_dat_o               = '0;
        if (ack_q) begin
            case (rgn_q)
                RGN_CSR: wb_dat_o = csr_rd_q;
                RGN_RES: wb_dat_o = res_word;
                default: wb_dat_o = '0;
            endcase
        end
    end

    assign wb_ack_o     = ack_q;
    assign cfg_kcols_o  = geom.kcols;
    assign cfg_icols_o  = geom.icols;
    assign cfg_nkern_o  = geom.nkern;
    assign cfg_stride_o = geom.stride;
    assign cfg_rcols_o  = outf.rcols;
    assign cfg_shift_o  = outf.shift;
    assign cfg_kmode_o  = outf.kmode;
    assign cfg_rmask_o  = outf.rmask;

    // R1
    ack_after_req_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_cyc_i && wb_stb_i && !wb_ack_o) |=> wb_ack_o);

    // R1
    ack_single_chk: assert property (@(posedge clk) disable iff (rst)
        wb_ack_o |=> !wb_ack_o);

    // R1
    ack_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_ack_o) |-> $past(wb_cyc_i && wb_stb_i));

    // R6
    start_needs_ack_chk: assert property (@(posedge clk) disable iff (rst)
        eng_start_o |-> wb_ack_o);

endmodule

// File: tb/conv_host_regs_tb_top.sv
module conv_host_regs_tb_top;

    localparam int RAM_AW = 6;
    localparam int AW     = RAM_AW + 4;
    localparam int IMG_W  = 24;
    localparam int KRN_W  = 24;
    localparam int RES_W  = 8;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              wb_cyc_i = 1'b0, wb_stb_i = 1'b0, wb_we_i = 1'b0;
    logic [AW-1:0]     wb_adr_i = '0;
    logic [31:0]       wb_dat_i = '0;
    logic [31:0]       wb_dat_o;
    logic              wb_ack_o;
    logic              eng_start_o, eng_srst_o;
    logic              eng_done_i = 1'b0, eng_ovf_i = 1'b0;
    logic [2:0]        cfg_kcols_o, cfg_nkern_o, cfg_rmask_o;
    logic [7:0]        cfg_icols_o, cfg_stride_o, cfg_rcols_o;
    logic [3:0]        cfg_shift_o;
    logic              cfg_kmode_o;
    logic [RAM_AW-1:0] eng_img_addr_i = '0, eng_krn_addr_i = '0, eng_res_addr_i = '0;
    logic [IMG_W-1:0]  eng_img_data_o;
    logic [KRN_W-1:0]  eng_krn_data_o;
    logic              eng_res_we_i = 1'b0;
    logic [RES_W-1:0]  eng_res_data_i = '0;

    always #2 clk = ~clk;

    conv_host_regs #(.RAM_AW(RAM_AW), .IMG_W(IMG_W), .KRN_W(KRN_W), .RES_W(RES_W)) dut_i (
        .clk(clk), .rst(rst),
        .wb_cyc_i(wb_cyc_i), .wb_stb_i(wb_stb_i), .wb_we_i(wb_we_i),
        .wb_adr_i(wb_adr_i), .wb_dat_i(wb_dat_i), .wb_dat_o(wb_dat_o), .wb_ack_o(wb_ack_o),
        .eng_start_o(eng_start_o), .eng_srst_o(eng_srst_o),
        .eng_done_i(eng_done_i), .eng_ovf_i(eng_ovf_i),
        .cfg_kcols_o(cfg_kcols_o), .cfg_icols_o(cfg_icols_o), .cfg_nkern_o(cfg_nkern_o),
        .cfg_stride_o(cfg_stride_o), .cfg_rcols_o(cfg_rcols_o), .cfg_shift_o(cfg_shift_o),
        .cfg_kmode_o(cfg_kmode_o), .cfg_rmask_o(cfg_rmask_o),
        .eng_img_addr_i(eng_img_addr_i), .eng_img_data_o(eng_img_data_o),
        .eng_krn_addr_i(eng_krn_addr_i), .eng_krn_data_o(eng_krn_data_o),
        .eng_res_we_i(eng_res_we_i), .eng_res_addr_i(eng_res_addr_i),
        .eng_res_data_i(eng_res_data_i)
    );

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;

    sb_item_t sb_q[$];
    int       n_vec  = 0;
    int       n_fail = 0;
    logic     rd_pend = 1'b0;
    logic     all_done = 1'b0;
    int       last_lat = 0;

    task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_vec++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // monitor: compares read data one step after the ack edge
    always @(posedge clk) begin
        #1;
        if (wb_ack_o && rd_pend) begin
            if (sb_q.size() == 0) begin
                check(wb_dat_o, 32'hDEAD_BEEF, "R1 unexpected read ack");
            end else begin
                sb_item_t it;
                it = sb_q.pop_front();
                check(wb_dat_o, it.exp, it.tag);
            end
        end
    end

    // called and returns at a falling edge
    task automatic bus_op(input logic we, input logic [AW-1:0] adr, input logic [31:0] dat);
        int lat;
        if (wb_ack_o) @(negedge clk);
        wb_cyc_i = 1'b1; wb_stb_i = 1'b1; wb_we_i = we;
        wb_adr_i = adr; wb_dat_i = dat; rd_pend = !we;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!wb_ack_o && lat < 8);
        last_lat = lat;
        wb_cyc_i = 1'b0; wb_stb_i = 1'b0; wb_we_i = 1'b0; rd_pend = 1'b0;
    endtask

    task automatic bus_wr(input logic [AW-1:0] adr, input logic [31:0] dat);
        bus_op(1'b1, adr, dat);
    endtask

    task automatic bus_rd(input logic [AW-1:0] adr, input logic [31:0] exp, input string tag);
        sb_item_t it;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        bus_op(1'b0, adr, 32'h0);
    endtask

    task automatic pulse_done();
        eng_done_i = 1'b1;
        @(negedge clk);
        eng_done_i = 1'b0;
    endtask

    task automatic pulse_ovf();
        eng_ovf_i = 1'b1;
        @(negedge clk);
        eng_ovf_i = 1'b0;
    endtask

    task automatic eng_res_write(input logic [RAM_AW-1:0] a, input logic [RES_W-1:0] d);
        eng_res_we_i = 1'b1; eng_res_addr_i = a; eng_res_data_i = d;
        @(negedge clk);
        eng_res_we_i = 1'b0;
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!all_done) begin
            n_vec++;
            n_fail++;
            $display("FAIL R1: actual hung bus, expected test end");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // reset state
        check({31'd0, wb_ack_o}, 32'd0, "R5 ack low after reset");
        check({30'd0, eng_start_o, eng_srst_o}, 32'd0, "R5 no engine pulse after reset");
        bus_rd(10'h000, 32'h0, "R5 control word reset value");
        check(last_lat, 1, "R1 read acked one cycle after request");
        @(negedge clk);
        check({31'd0, wb_ack_o}, 32'd0, "R1 ack lasts one cycle");
        bus_rd(10'h004, 32'h0, "R10 geometry reset value");
        bus_rd(10'h008, 32'h0, "R11 output format reset value");

        // geometry word
        bus_wr(10'h004, 32'hFFFF_FFFF);
        check(last_lat, 1, "R1 write acked one cycle after request");
        bus_rd(10'h004, 32'hFF07_FF07, "R10 reserved geometry bits read zero");
        bus_wr(10'h004, 32'h1203_4505);
        check({29'd0, cfg_kcols_o}, 32'd5, "R10 kernel columns output");
        check({24'd0, cfg_icols_o}, 32'h45, "R10 image columns output");
        check({29'd0, cfg_nkern_o}, 32'd3, "R10 kernel count output");
        check({24'd0, cfg_stride_o}, 32'h12, "R10 stride output");
        bus_rd(10'h004, 32'h1203_4505, "R10 geometry readback");

        // output format word
        bus_wr(10'h008, 32'hFFFF_FFFF);
        bus_rd(10'h008, 32'h001D_0FFF, "R11 reserved format bits read zero");
        bus_wr(10'h008, 32'h0009_0A3C);
        check({24'd0, cfg_rcols_o}, 32'h3C, "R11 result columns output");
        check({28'd0, cfg_shift_o}, 32'hA, "R11 shift output");
        check({31'd0, cfg_kmode_o}, 32'd1, "R11 kernel mode output");
        check({29'd0, cfg_rmask_o}, 32'd2, "R11 row mask output");
        bus_rd(10'h008, 32'h0009_0A3C, "R11 format readback");

        // reserved register offsets
        bus_wr(10'h00C, 32'hFFFF_FFFF);
        bus_wr(10'h0F0, 32'hFFFF_FFFF);
        bus_rd(10'h00C, 32'h0, "R12 offset 0x00C reads zero");
        bus_rd(10'h0FC, 32'h0, "R12 offset 0x0FC reads zero");
        bus_rd(10'h004, 32'h1203_4505, "R12 geometry untouched by reserved write");
        bus_rd(10'h008, 32'h0009_0A3C, "R12 format untouched by reserved write");
        bus_rd(10'h000, 32'h0, "R12 control untouched by reserved write");

        // image and kernel stores
        bus_wr(10'h104, 32'hAABB_CCDD);
        bus_wr(10'h1FC, 32'h0012_3456);
        bus_wr(10'h2FC, 32'h1122_3344);
        bus_wr(10'h200, 32'hFF65_4321);
        bus_rd(10'h104, 32'h0, "R3 image region reads zero");
        bus_rd(10'h2FC, 32'h0, "R3 kernel region reads zero");
        @(negedge clk);
        eng_img_addr_i = 6'd1; eng_krn_addr_i = 6'd63;
        @(negedge clk);
        check({8'd0, eng_img_data_o}, 32'h00BB_CCDD, "R3 image word 1 at engine port");
        check({8'd0, eng_krn_data_o}, 32'h0022_3344, "R3 kernel word 63 at engine port");
        eng_img_addr_i = 6'd63; eng_krn_addr_i = 6'd0;
        @(negedge clk);
        check({8'd0, eng_img_data_o}, 32'h0012_3456, "R2 image word 63 at offset 0x1FC");
        check({8'd0, eng_krn_data_o}, 32'h0065_4321, "R2 kernel word 0 at offset 0x200");

        // result store
        eng_res_write(6'd3, 8'h5A);
        eng_res_write(6'd63, 8'hC3);
        eng_res_write(6'd0, 8'h81);
        bus_rd(10'h30C, 32'h0000_005A, "R4 result word 3");
        bus_rd(10'h3FC, 32'h0000_00C3, "R4 result word 63");
        bus_rd(10'h300, 32'h0000_0081, "R2 result word 0 at offset 0x300");
        bus_wr(10'h30C, 32'hFFFF_FFFF);
        bus_rd(10'h30C, 32'h0000_005A, "R4 host write to result ignored");

        // go pulse
        bus_wr(10'h000, 32'h0000_0004);
        check({31'd0, eng_start_o}, 32'd1, "R6 start high in ack cycle");
        @(negedge clk);
        check({31'd0, eng_start_o}, 32'd0, "R6 start lasts one cycle");
        bus_rd(10'h000, 32'h0, "R5 go bit reads zero");

        // done status
        pulse_done();
        bus_rd(10'h000, 32'h1, "R7 done set by engine");
        bus_wr(10'h000, 32'h0);
        bus_rd(10'h000, 32'h1, "R7 done kept without go");
        eng_done_i = 1'b1;
        bus_wr(10'h000, 32'h0000_0004);
        eng_done_i = 1'b0;
        check({31'd0, eng_start_o}, 32'd1, "R6 start with concurrent done");
        bus_rd(10'h000, 32'h0, "R7 go clear beats concurrent done");

        // overflow status
        pulse_ovf();
        bus_rd(10'h000, 32'h2, "R8 overflow set by engine");
        @(negedge clk);
        bus_rd(10'h000, 32'h2, "R8 overflow sticky");
        bus_wr(10'h000, 32'h0);
        bus_rd(10'h000, 32'h2, "R8 writing zero keeps overflow");
        bus_wr(10'h000, 32'h2);
        bus_rd(10'h000, 32'h0, "R8 writing one clears overflow");
        eng_ovf_i = 1'b1;
        bus_wr(10'h000, 32'h2);
        eng_ovf_i = 1'b0;
        bus_rd(10'h000, 32'h2, "R8 overflow report beats clear");

        // soft reset
        bus_wr(10'h000, 32'h8);
        check({31'd0, eng_srst_o}, 32'd1, "R9 soft reset high in ack cycle");
        check({31'd0, eng_start_o}, 32'd0, "R9 soft reset raises no start");
        @(negedge clk);
        check({31'd0, eng_srst_o}, 32'd0, "R9 soft reset lasts one cycle");
        bus_rd(10'h000, 32'h0, "R9 soft reset clears overflow");
        bus_rd(10'h004, 32'h1203_4505, "R9 geometry kept over soft reset");
        bus_rd(10'h008, 32'h0009_0A3C, "R9 format kept over soft reset");

        repeat (3) @(negedge clk);
        check(sb_q.size(), 0, "R1 every read acknowledged");
        all_done = 1'b1;
        summary();
        $finish;
    end

endmodule